// File: doc/BRIEF.md
# Lockstep Vector Lane Sequencer

This block is a small data-parallel engine. A central sequencer holds a short program in an internal instruction store and issues at most one instruction per cycle. Every lane receives the same instruction in the same cycle and applies it to its own private register file. The sequencer alone keeps the loop counter and decides whether to branch back or stop, so the lanes never see control flow. Once the program ends, nothing more reaches the lanes.

Before a run, a host fills the instruction store and loads lane registers through a write port. It then pulses `start` with an iteration limit. Beyond element-wise integer add and subtract, the instruction set has a sum across all lanes, which goes through a pipelined adder tree while issue waits, and a key search that reports the lowest matching lane. A per-lane active bit handles data-dependent conditionals: a compare switches lanes off, an invert selects the other path, and a restore switches all lanes back on. Results are read back one register number at a time, across all lanes at once.

Top module: `simd_bcast_ctrl`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `srch_hit` and `red_sum` are 0, every lane register reads 0, and every lane is active.
- R2: An instruction word is {op[16:13], dst[12:10], srca[9:7], srcb[6:4], tgt[3:0]}, with op codes NOP=0, VADD=1, VSUB=2, RADD=3, SRCH=4, CMPLT=5, MINV=6, MALL=7, LOOP=8, END=9. VADD and VSUB write r[srca]+r[srcb] or r[srca]-r[srcb] (modulo 2^DW) into r[dst] of every active lane in the same cycle.
- R3: LOOP adds one to an internal iteration count that `start` clears. It jumps to tgt while the new count is below the `loop_count` sampled at start, and otherwise ends the run. The body therefore runs max(loop_count,1) times.
- R4: Counting from the clock edge that accepts `start`, `done` goes high after exactly (instructions issued + stall cycles) further edges, stays high for one cycle, and coincides with `busy` low. No lane register changes after the run ends.
- R5: A `start` pulse while `busy` is high is ignored: the running program, its loop count and its timing are unaffected.
- R6: RADD places the sum of r[srca] over all lanes (modulo 2^DW, lane active bits ignored) on `red_sum`. The next instruction issues ceil(log2(LANES)) cycles after the RADD, and `red_sum` holds its value until the next RADD.
- R7: SRCH compares r[srca] of every lane with `srch_key`. The next cycle, `srch_hit` is 1 and `srch_idx` is the lowest matching lane, or `srch_hit` is 0 if no lane matches. Both hold until the next SRCH.
- R8: CMPLT clears the active bit of each lane where r[srca] < r[srcb] (unsigned) is false. MINV inverts every lane's active bit and MALL sets all of them. An inactive lane keeps its registers unchanged.
- R9: Accepting `start` sets the active bit of every lane.
- R10: `lane_we` writes `lane_wdata` into register `lane_reg` of lane `lane_sel`. `rd_data` carries register `rd_reg` of lane i in bits [i*DW +: DW].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Instruction store write enable |
| prog_addr | input | 4 | Instruction store address |
| prog_wdata | input | 17 | Instruction word |
| lane_we | input | 1 | Lane register preload enable |
| lane_sel | input | LANE_W | Lane selected for preload |
| lane_reg | input | 3 | Register number for preload |
| lane_wdata | input | DW | Preload data |
| start | input | 1 | Start pulse, accepted only when idle |
| loop_count | input | CNT_W | Iteration limit for LOOP |
| srch_key | input | DW | Key for SRCH |
| busy | output | 1 | Program running |
| done | output | 1 | One-cycle pulse when the run ends |
| rd_reg | input | 3 | Register number for readback |
| rd_data | output | LANES*DW | That register in every lane |
| red_sum | output | DW | Result of the last RADD |
| srch_idx | output | LANE_W | Lowest matching lane of the last SRCH |
| srch_hit | output | 1 | Last SRCH found a match |

## Verification
The bench targets loop exit at the boundaries: a limit of one and a limit of zero must each run the body once, so a design that ran the body once more would leave an accumulator one step too far. It checks the exact cycle count from start to done on every run, which exposes a missing or over-long reduce stall and a restart triggered by a second start pulse in mid-run. For search, it uses keys with two matching lanes and with none, which catches a design that reports the highest match or keeps a stale hit flag. Conditional runs check that masked lanes keep their old value, that the invert and restore ops flip the right lanes, and that a new start reactivates lanes left switched off by the previous program.

// File: rtl/simd_bcast_pkg.sv
package simd_bcast_pkg;

    localparam int REG_W   = 3;
    localparam int PC_W    = 4;
    localparam int OP_W    = 4;
    localparam int INSTR_W = OP_W + 3 * REG_W + PC_W;

    typedef enum logic [OP_W-1:0] {
        OP_NOP   = 4'd0,
        OP_VADD  = 4'd1,
        OP_VSUB  = 4'd2,
        OP_RADD  = 4'd3,
        OP_SRCH  = 4'd4,
        OP_CMPLT = 4'd5,
        OP_MINV  = 4'd6,
        OP_MALL  = 4'd7,
        OP_LOOP  = 4'd8,
        OP_END   = 4'd9
    } op_e;

    typedef struct packed {
        op_e              op;
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] srca;
        logic [REG_W-1:0] srcb;
        logic [PC_W-1:0]  tgt;
    } instr_t;

    // floor(log2(v)) for v >= 1
    function automatic int flog2(input int v);
        int r;
        r = 0;
        for (int x = v; x > 1; x = x >> 1) r++;
        return r;
    endfunction

endpackage

// File: rtl/simd_seq.sv
module simd_seq
    import simd_bcast_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int RED_LAT = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               prog_we,
    input  logic [PC_W-1:0]    prog_addr,
    input  logic [INSTR_W-1:0] prog_wdata,
    input  logic               start,
    input  logic [CNT_W-1:0]   loop_count,
    input  logic               red_last,
    output logic               busy,
    output logic               done,
    output logic               iss_vld,
    output op_e                iss_op,
    output logic [REG_W-1:0]   iss_dst,
    output logic [REG_W-1:0]   iss_srca,
    output logic [REG_W-1:0]   iss_srcb,
    output logic               restart
);
    localparam int PDEPTH = 1 << PC_W;

    typedef enum logic [1:0] {S_IDLE, S_RUN, S_WAIT} st_e;

    st_e              st_q;
    logic [PC_W-1:0]  pc_q;
    logic [CNT_W-1:0] iter_q;
    logic [CNT_W-1:0] lim_q;
    logic             done_q;
    instr_t           mem_q [PDEPTH];
    instr_t           cur;
    logic [CNT_W:0]   iter_nx;

    assign cur      = mem_q[pc_q];
    assign iss_vld  = (st_q == S_RUN);
    assign iss_op   = cur.op;
    assign iss_dst  = cur.dst;
    assign iss_srca = cur.srca;
    assign iss_srcb = cur.srcb;
    assign busy     = (st_q != S_IDLE);
    assign done     = done_q;
    assign restart  = (st_q == S_IDLE) && start;
    assign iter_nx  = {1'b0, iter_q} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < PDEPTH; k++) mem_q[k] <= '0;
        end else if (prog_we) begin
            mem_q[prog_addr] <= instr_t'(prog_wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_IDLE;
            pc_q   <= '0;
            iter_q <= '0;
            lim_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                S_IDLE: begin
                    if (start) begin
                        pc_q   <= '0;
                        iter_q <= '0;
                        lim_q  <= loop_count;
                        st_q   <= S_RUN;
                    end
                end
                S_RUN: begin
                    case (cur.op)
                        OP_LOOP: begin
                            if (iter_nx < {1'b0, lim_q}) begin
                                iter_q <= iter_nx[CNT_W-1:0];
                                pc_q   <= cur.tgt;
                            end else begin
                                st_q   <= S_IDLE;
                                done_q <= 1'b1;
                            end
                        end
                        OP_END: begin
                            st_q   <= S_IDLE;
                            done_q <= 1'b1;
                        end
                        OP_RADD: begin
                            pc_q <= pc_q + 1'b1;
                            if (RED_LAT > 1) st_q <= S_WAIT;
                        end
                        default: pc_q <= pc_q + 1'b1;
                    endcase
                end
                S_WAIT: begin
                    if (red_last) st_q <= S_RUN;
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/simd_lane.sv
module simd_lane
    import simd_bcast_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_we,
    input  logic [REG_W-1:0] host_reg,
    input  logic [DW-1:0]    host_wdata,
    input  logic             iss_vld,
    input  op_e              op,
    input  logic [REG_W-1:0] dst,
    input  logic [REG_W-1:0] srca,
    input  logic [REG_W-1:0] srcb,
    input  logic             act_all,
    input  logic [REG_W-1:0] rd_reg,
    output logic [DW-1:0]    opa,
    output logic [DW-1:0]    rd_val
);
    localparam int RDEPTH = 1 << REG_W;

    logic [DW-1:0] regs_q [RDEPTH];
    logic          act_q;
    logic [DW-1:0] vb;

    assign opa    = regs_q[srca];
    assign vb     = regs_q[srcb];
    assign rd_val = regs_q[rd_reg];

    // active bit for divergent paths
    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b1;
        end else if (act_all) begin
            act_q <= 1'b1;
        end else if (iss_vld) begin
            case (op)
                OP_CMPLT: act_q <= act_q & (opa < vb);
                OP_MINV:  act_q <= ~act_q;
                OP_MALL:  act_q <= 1'b1;
                default:  act_q <= act_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < RDEPTH; k++) regs_q[k] <= '0;
        end else if (iss_vld && act_q && op == OP_VADD) begin
            regs_q[dst] <= opa + vb;
        end else if (iss_vld && act_q && op == OP_VSUB) begin
            regs_q[dst] <= opa - vb;
        end else if (host_we) begin
            regs_q[host_reg] <= host_wdata;
        end
    end

endmodule

// File: rtl/simd_rtree.sv
module simd_rtree
    import simd_bcast_pkg::*;
#(
    parameter int LANES = 4,
    parameter int DW    = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                go,
    input  logic [LANES*DW-1:0] vals,
    output logic [DW-1:0]       sum,
    output logic                last
);
    localparam int LAT  = $clog2(LANES);
    localparam int P    = 1 << LAT;
    localparam int PV_W = (LAT > 1) ? LAT - 1 : 1;

    logic [DW-1:0]   node [1:P-1];
    logic [DW-1:0]   kid  [2:2*P-1];
    logic [PV_W-1:0] pv;
    logic [LAT-1:0]  sen;

    // sen[s]: inputs of stage s are ready (stage 0 sits next to the leaves)
    assign sen  = LAT'({pv, go});
    assign last = sen[LAT-1];
    assign sum  = node[1];

    always_comb begin
        for (int k = 2; k < P; k++) kid[k] = node[k];
        for (int k = P; k < 2 * P; k++) begin
            if (k - P < LANES) kid[k] = vals[(k-P)*DW +: DW];
            else               kid[k] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pv <= '0;
            for (int k = 1; k < P; k++) node[k] <= '0;
        end else begin
            pv[0] <= go;
            for (int s = 1; s < LAT - 1; s++) pv[s] <= pv[s-1];
            for (int k = 1; k < P; k++) begin
                if (sen[LAT-1-flog2(k)]) node[k] <= kid[2*k] + kid[2*k+1];
            end
        end
    end

endmodule

// File: rtl/simd_match.sv
module simd_match #(
    parameter int LANES  = 4,
    parameter int DW     = 16,
    parameter int LANE_W = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                go,
    input  logic [LANES*DW-1:0] vals,
    input  logic [DW-1:0]       key,
    output logic                hit,
    output logic [LANE_W-1:0]   idx
);
    logic              fnd;
    logic [LANE_W-1:0] sel;

    // scan downward so the lowest matching lane wins
    always_comb begin
        fnd = 1'b0;
        sel = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (vals[i*DW +: DW] == key) begin
                fnd = 1'b1;
                sel = LANE_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hit <= 1'b0;
            idx <= '0;
        end else if (go) begin
            hit <= fnd;
            idx <= sel;
        end
    end

endmodule

// File: rtl/simd_bcast_ctrl.sv
module simd_bcast_ctrl
    import simd_bcast_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int DW     = 16,
    parameter int CNT_W  = 8,
    parameter int LANE_W = $clog2(LANES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                prog_we,
    input  logic [PC_W-1:0]     prog_addr,
    input  logic [INSTR_W-1:0]  prog_wdata,
    input  logic                lane_we,
    input  logic [LANE_W-1:0]   lane_sel,
    input  logic [REG_W-1:0]    lane_reg,
    input  logic [DW-1:0]       lane_wdata,
    input  logic                start,
    input  logic [CNT_W-1:0]    loop_count,
    input  logic [DW-1:0]       srch_key,
    output logic                busy,
    output logic                done,
    input  logic [REG_W-1:0]    rd_reg,
    output logic [LANES*DW-1:0] rd_data,
    output logic [DW-1:0]       red_sum,
    output logic [LANE_W-1:0]   srch_idx,
    output logic                srch_hit
);
    localparam int RED_LAT = $clog2(LANES);

    logic               iss_vld;
    op_e                iss_op;
    logic [REG_W-1:0]   iss_dst;
    logic [REG_W-1:0]   iss_srca;
    logic [REG_W-1:0]   iss_srcb;
    logic               restart;
    logic               red_last;
    logic [LANES*DW-1:0] opa_flat;

    simd_seq #(
        .CNT_W   (CNT_W),
        .RED_LAT (RED_LAT)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .prog_we    (prog_we),
        .prog_addr  (prog_addr),
        .prog_wdata (prog_wdata),
        .start      (start),
        .loop_count (loop_count),
        .red_last   (red_last),
        .busy       (busy),
        .done       (done),
        .iss_vld    (iss_vld),
        .iss_op     (iss_op),
        .iss_dst    (iss_dst),
        .iss_srca   (iss_srca),
        .iss_srcb   (iss_srcb),
        .restart    (restart)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        simd_lane #(
            .DW (DW)
        ) u_lane (
            .clk        (clk),
            .rst        (rst),
            .host_we    (lane_we && (lane_sel == LANE_W'(i))),
            .host_reg   (lane_reg),
            .host_wdata (lane_wdata),
            .iss_vld    (iss_vld),
            .op         (iss_op),
            .dst        (iss_dst),
            .srca       (iss_srca),
            .srcb       (iss_srcb),
            .act_all    (restart),
            .rd_reg     (rd_reg),
            .opa        (opa_flat[i*DW +: DW]),
            .rd_val     (rd_data[i*DW +: DW])
        );
    end

    simd_rtree #(
        .LANES (LANES),
        .DW    (DW)
    ) u_rtree (
        .clk  (clk),
        .rst  (rst),
        .go   (iss_vld && iss_op == OP_RADD),
        .vals (opa_flat),
        .sum  (red_sum),
        .last (red_last)
    );

    simd_match #(
        .LANES  (LANES),
        .DW     (DW),
        .LANE_W (LANE_W)
    ) u_match (
        .clk  (clk),
        .rst  (rst),
        .go   (iss_vld && iss_op == OP_SRCH),
        .vals (opa_flat),
        .key  (srch_key),
        .hit  (srch_hit),
        .idx  (srch_idx)
    );

endmodule

// File: rtl/simd_bcast_chk.sv
module simd_bcast_chk
    import simd_bcast_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              iss_vld,
    input op_e               iss_op,
    input logic              srch_hit,
    input logic [LANE_W-1:0] srch_idx
);

    a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r4_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r5_busy_from_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    a_r2_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !iss_vld);

    a_r3_end_done: assert property (@(posedge clk) disable iff (rst)
        (iss_vld && iss_op == OP_END) |=> done);

    a_r6_stall: assert property (@(posedge clk) disable iff (rst)
        (LANES > 2 && iss_vld && iss_op == OP_RADD) |=> !iss_vld);

    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !(iss_vld && iss_op == OP_SRCH) |=> ($stable(srch_hit) && $stable(srch_idx)));

endmodule

bind simd_bcast_ctrl simd_bcast_chk #(
    .LANES  (LANES),
    .LANE_W (LANE_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .iss_vld  (iss_vld),
    .iss_op   (iss_op),
    .srch_hit (srch_hit),
    .srch_idx (srch_idx)
);

// File: tb/test_simd_bcast_ctrl.sv
`timescale 1ns/1ps
module test_simd_bcast_ctrl;
    import simd_bcast_pkg::*;

    localparam int LANES  = 4;
    localparam int DW     = 16;
    localparam int CNT_W  = 8;
    localparam int LANE_W = $clog2(LANES);
    localparam int LAT    = $clog2(LANES);

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                prog_we = 1'b0;
    logic [PC_W-1:0]     prog_addr = '0;
    logic [INSTR_W-1:0]  prog_wdata = '0;
    logic                lane_we = 1'b0;
    logic [LANE_W-1:0]   lane_sel = '0;
    logic [REG_W-1:0]    lane_reg = '0;
    logic [DW-1:0]       lane_wdata = '0;
    logic                start = 1'b0;
    logic [CNT_W-1:0]    loop_count = '0;
    logic [DW-1:0]       srch_key = '0;
    logic                busy, done;
    logic [REG_W-1:0]    rd_reg = '0;
    logic [LANES*DW-1:0] rd_data;
    logic [DW-1:0]       red_sum;
    logic [LANE_W-1:0]   srch_idx;
    logic                srch_hit;

    always #4 clk = ~clk;

    simd_bcast_ctrl #(.LANES(LANES), .DW(DW), .CNT_W(CNT_W)) i_simd_bcast_ctrl (
        .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_wdata(prog_wdata), .lane_we(lane_we), .lane_sel(lane_sel),
        .lane_reg(lane_reg), .lane_wdata(lane_wdata), .start(start),
        .loop_count(loop_count), .srch_key(srch_key), .busy(busy), .done(done),
        .rd_reg(rd_reg), .rd_data(rd_data), .red_sum(red_sum),
        .srch_idx(srch_idx), .srch_hit(srch_hit)
    );

    // scoreboard item kinds
    localparam int K_REG = 0, K_RED = 1, K_HIT = 2, K_IDX = 3,
                   K_CYC = 4, K_BUSY = 5, K_DONE = 6;

    typedef struct {
        int          kind;
        int          sel;
        int          lane;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sbq[$];
    int    n_chk = 0;
    int    n_fail = 0;
    int    meas_cyc = 0;
    bit    finished = 0;

    function automatic logic [INSTR_W-1:0] enc(op_e op, int d, int a, int b, int t);
        return {op, REG_W'(d), REG_W'(a), REG_W'(b), PC_W'(t)};
    endfunction

    task automatic expect_item(int kind, int sel, int lane, logic [31:0] exp, string tag);
        item_t it;
        it.kind = kind; it.sel = sel; it.lane = lane; it.exp = exp; it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic drain();
        wait (sbq.size() == 0);
        @(negedge clk);
        @(negedge clk);
    endtask

    // monitor: pops expectations, samples ports at the falling edge
    initial begin
        item_t       it;
        logic [31:0] act;
        forever begin
            wait (sbq.size() != 0);
            it = sbq.pop_front();
            rd_reg = REG_W'(it.sel);
            @(negedge clk);
            case (it.kind)
                K_REG:   act = 32'(rd_data[it.lane*DW +: DW]);
                K_RED:   act = 32'(red_sum);
                K_HIT:   act = 32'(srch_hit);
                K_IDX:   act = 32'(srch_idx);
                K_CYC:   act = 32'(meas_cyc);
                K_BUSY:  act = 32'(busy);
                default: act = 32'(done);
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s kind=%0d lane=%0d reg=%0d actual=%0d expected=%0d",
                         it.tag, it.kind, it.lane, it.sel, act, it.exp);
            end
        end
    end

    task automatic pw(int addr, logic [INSTR_W-1:0] w);
        @(negedge clk);
        prog_we = 1'b1; prog_addr = PC_W'(addr); prog_wdata = w;
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic lw(int lane, int r, int v);
        @(negedge clk);
        lane_we = 1'b1; lane_sel = LANE_W'(lane); lane_reg = REG_W'(r); lane_wdata = DW'(v);
        @(negedge clk);
        lane_we = 1'b0;
    endtask

    // run a program; restart_at > 0 pulses start again while busy
    task automatic run(int lim, int exp_cyc, int restart_at, string tag);
        int n;
        @(negedge clk);
        loop_count = CNT_W'(lim);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 400) begin
            start = (n == restart_at);
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        meas_cyc = n;
        expect_item(K_CYC, 0, 0, 32'(exp_cyc), tag);
        expect_item(K_DONE, 0, 0, 32'd0, "R4 done one cycle");
        drain();
    endtask

    task automatic chk_lanes(int r, int mul_lo, int mul_hi, int split, string tag);
        for (int i = 0; i < LANES; i++)
            expect_item(K_REG, r, i, 32'(DW'((i < split ? mul_lo : mul_hi) * (i + 1))), tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int sum;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        expect_item(K_BUSY, 0, 0, 32'd0, "R1 busy");
        expect_item(K_DONE, 0, 0, 32'd0, "R1 done");
        expect_item(K_HIT, 0, 0, 32'd0, "R1 srch_hit");
        expect_item(K_RED, 0, 0, 32'd0, "R1 red_sum");
        for (int i = 0; i < LANES; i++) expect_item(K_REG, 1, i, 32'd0, "R1 lane reg");
        drain();

        // R10: preload lane registers
        for (int i = 0; i < LANES; i++) begin
            lw(i, 1, i + 1);
            lw(i, 2, 10 * (i + 1));
            lw(i, 3, (i % 2 == 0) ? 7 : 5);
            lw(i, 7, 3);
        end
        chk_lanes(1, 1, 1, LANES, "R10 preload r1");
        chk_lanes(2, 10, 10, LANES, "R10 preload r2");
        drain();

        // program A: r4=r1+r2; loop { r5=r5+r1 }
        pw(0, enc(OP_VADD, 4, 1, 2, 0));
        pw(1, enc(OP_VADD, 5, 5, 1, 0));
        pw(2, enc(OP_LOOP, 0, 0, 0, 1));

        // R3 R4 R5: three iterations, second start in mid-run
        run(3, 1 + 7, 3, "R4 R5 cycles loop_count=3");
        chk_lanes(4, 11, 11, LANES, "R2 VADD r4");
        chk_lanes(5, 3, 3, LANES, "R3 R5 r5 after 3 iterations");
        drain();
        repeat (10) @(negedge clk);
        chk_lanes(5, 3, 3, LANES, "R4 no issue after end");
        drain();

        run(1, 1 + 3, 0, "R3 cycles loop_count=1");
        chk_lanes(5, 4, 4, LANES, "R3 loop_count=1 single pass");
        drain();
        run(0, 1 + 3, 0, "R3 cycles loop_count=0");
        chk_lanes(5, 5, 5, LANES, "R3 loop_count=0 single pass");
        drain();

        // program B: reduce then subtract
        pw(0, enc(OP_RADD, 0, 2, 0, 0));
        pw(1, enc(OP_VSUB, 6, 2, 1, 0));
        pw(2, enc(OP_END, 0, 0, 0, 0));
        run(1, 1 + 3 + (LAT - 1), 0, "R6 cycles with stall");
        sum = 0;
        for (int i = 0; i < LANES; i++) sum += 10 * (i + 1);
        expect_item(K_RED, 0, 0, 32'(DW'(sum)), "R6 reduce sum");
        chk_lanes(6, 9, 9, LANES, "R2 VSUB r6");
        drain();

        // program C: search r3 for key
        pw(0, enc(OP_SRCH, 0, 3, 0, 0));
        pw(1, enc(OP_END, 0, 0, 0, 0));
        srch_key = 16'd5;
        run(1, 3, 0, "R7 cycles");
        expect_item(K_HIT, 0, 0, 32'd1, "R7 key 5 hit");
        expect_item(K_IDX, 0, 0, 32'd1, "R7 key 5 lowest lane");
        drain();
        srch_key = 16'd7;
        run(1, 3, 0, "R7 cycles");
        expect_item(K_HIT, 0, 0, 32'd1, "R7 key 7 hit");
        expect_item(K_IDX, 0, 0, 32'd0, "R7 key 7 lowest lane");
        drain();
        srch_key = 16'd9;
        run(1, 3, 0, "R7 cycles");
        expect_item(K_HIT, 0, 0, 32'd0, "R7 key 9 no match");
        expect_item(K_RED, 0, 0, 32'(DW'(sum)), "R6 red_sum held");
        drain();

        // program D: divergent branch on r1 < 3
        pw(0, enc(OP_CMPLT, 0, 1, 7, 0));
        pw(1, enc(OP_VADD, 6, 1, 1, 0));
        pw(2, enc(OP_MINV, 0, 0, 0, 0));
        pw(3, enc(OP_VSUB, 6, 2, 1, 0));
        pw(4, enc(OP_END, 0, 0, 0, 0));
        run(1, 6, 0, "R8 cycles");
        chk_lanes(6, 2, 9, 2, "R8 masked paths r6");
        drain();

        // program E: start reactivates all lanes
        pw(0, enc(OP_VADD, 5, 1, 1, 0));
        pw(1, enc(OP_END, 0, 0, 0, 0));
        run(1, 3, 0, "R9 cycles");
        chk_lanes(5, 2, 2, LANES, "R9 all lanes active");
        drain();

        // program F: compare, restore all, write
        pw(0, enc(OP_CMPLT, 0, 1, 7, 0));
        pw(1, enc(OP_MALL, 0, 0, 0, 0));
        pw(2, enc(OP_VSUB, 4, 2, 1, 0));
        pw(3, enc(OP_END, 0, 0, 0, 0));
        run(1, 5, 0, "R8 cycles");
        chk_lanes(4, 9, 9, LANES, "R8 MALL restores lanes");
        drain();

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule